// File: doc/BRIEF.md
# Partitioned Buffer Slot Allocator

This block tracks ownership of a fixed pool of message buffer slots that two traffic classes share: inbound messages and outbound requests. It keeps one used bit per slot and does not store any payload. On request it hands out the index of a free slot.

An allocation request has a class bit. An inbound request may take any slot. An outbound request may only take a slot from the upper three quarters of the pool. The lowest quarter therefore always stays available to inbound traffic. A reply can still land even when pending outbound requests have filled every slot they are allowed to use.

A request is searched, granted and marked used in the same clock edge. The result comes back from a register one cycle later. A separate free port returns a slot to the pool. Two free-slot counts, one for the reserved quarter and one for the shared upper region, show how full each partition is.

Top module: `slot_pool_alloc`

## Requirements
- R1: After reset every slot is free. `free_cnt_lo` equals NUM_SLOTS/4, `free_cnt_hi` equals 3*NUM_SLOTS/4, and `grant_valid` is low.
- R2: An inbound request (`req_outbound`=0) is granted the lowest-index slot whose used bit is clear, searching from slot 0.
- R3: An outbound request (`req_outbound`=1) is granted the lowest free slot with index at least NUM_SLOTS/4. It never receives a slot below that index, even when one is free.
- R4: When no slot that the class may use is free, `grant_fail` is high with `grant_valid`, `grant_idx` is 0, and no used bit changes.
- R5: A granted slot is marked used in the same edge that selects it, so a later request never receives a slot that is still held.
- R6: A free of slot k clears its used bit, and slot k can be granted to a request presented in the next cycle.
- R7: An allocation and a free of a different slot in the same cycle both take effect.
- R8: When a request and a free arrive in the same cycle, the free is applied before the search, so the freed slot can be granted to that request.
- R9: `grant_valid` is high in exactly the cycle after a cycle with `req_valid` high. `req_ready` is always high.
- R10: `free_cnt_lo` counts the free slots below NUM_SLOTS/4, and `free_cnt_hi` counts the free slots at or above NUM_SLOTS/4.
- R11: When the reserved quarter is full, an inbound request is granted the lowest free slot in the upper region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Allocation request this cycle |
| req_ready | output | 1 | Request accepted (always high) |
| req_outbound | input | 1 | Class of request: 0 inbound, 1 outbound |
| free_valid | input | 1 | Return a slot this cycle |
| free_idx | input | $clog2(NUM_SLOTS) | Slot being returned |
| grant_valid | output | 1 | Registered result of the previous cycle's request |
| grant_fail | output | 1 | No eligible slot was free |
| grant_idx | output | $clog2(NUM_SLOTS) | Granted slot index (0 on failure) |
| free_cnt_lo | output | $clog2(NUM_SLOTS+1) | Free slots in the reserved lower quarter |
| free_cnt_hi | output | $clog2(NUM_SLOTS+1) | Free slots in the upper three quarters |

## Verification
The bench fills the reserved quarter with inbound grants and checks that the next inbound request spills into the upper region. A design that kept inbound traffic out of the upper region would report a failure at that point instead of granting a slot. It then exhausts the outbound region and frees a reserved slot together with an outbound request. The request must still fail; a design that started the outbound search at slot 0 would grant slot 3 there. It also frees a slot in the same cycle as a request and expects that slot to be granted. A design that searched before applying the free would pick a different slot, or fail when the pool is otherwise full. A free paired with a request for another slot must show up in both counts; a design that let either event take priority would lose a used bit or a grant.

// File: rtl/slot_pool_pkg.sv
package slot_pool_pkg;

    // Traffic class carried by an allocation request
    typedef enum logic {
        CLS_INBOUND  = 1'b0,
        CLS_OUTBOUND = 1'b1
    } slot_class_e;

endpackage

// File: rtl/pool_first_free.sv
// Lowest-index priority search over a vector of eligible slots.
module pool_first_free #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  avail,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        // Walk from the top down so the lowest set bit is written last
        for (int i = N - 1; i >= 0; i--) begin
            if (avail[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pool_free_count.sv
// Population count of free slots in one partition.
module pool_free_count #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  free_bits,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CW'(free_bits[i]);
        end
    end
endmodule

// File: rtl/slot_pool_alloc.sv
module slot_pool_alloc
    import slot_pool_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int IW        = $clog2(NUM_SLOTS),
    parameter int CW        = $clog2(NUM_SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_outbound,
    input  logic          free_valid,
    input  logic [IW-1:0] free_idx,
    output logic          grant_valid,
    output logic          grant_fail,
    output logic [IW-1:0] grant_idx,
    output logic [CW-1:0] free_cnt_lo,
    output logic [CW-1:0] free_cnt_hi
);
    localparam int QUARTER = NUM_SLOTS / 4;
    localparam int UPPER   = NUM_SLOTS - QUARTER;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] used;
        logic                 gvalid;
        logic                 gfail;
        logic [IW-1:0]        gidx;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SLOTS-1:0] used_after_free;
    logic [NUM_SLOTS-1:0] eligible;
    logic [NUM_SLOTS-1:0] class_mask;
    logic                 hit_found;
    logic [IW-1:0]        hit_idx;
    slot_class_e          req_class;

    assign req_class = slot_class_e'(req_outbound);

    // Outbound traffic is fenced out of the reserved lower quarter
    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_mask
            if (g < QUARTER) begin : g_lo
                assign class_mask[g] = (req_class == CLS_INBOUND);
            end else begin : g_hi
                assign class_mask[g] = 1'b1;
            end
        end
    endgenerate

    // A returned slot is released before the search sees the pool
    always_comb begin
        used_after_free = st_q.used;
        if (free_valid) begin
            used_after_free[free_idx] = 1'b0;
        end
        eligible = ~used_after_free & class_mask;
    end

    pool_first_free #(.N(NUM_SLOTS), .IW(IW)) u_find (
        .avail (eligible),
        .found (hit_found),
        .idx   (hit_idx)
    );

    always_comb begin
        st_d        = st_q;
        st_d.used   = used_after_free;
        st_d.gvalid = req_valid;
        st_d.gfail  = 1'b0;
        st_d.gidx   = '0;
        if (req_valid) begin
            if (hit_found) begin
                st_d.used[hit_idx] = 1'b1;
                st_d.gidx          = hit_idx;
            end else begin
                st_d.gfail = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pool_free_count #(.N(QUARTER), .CW(CW)) u_cnt_lo (
        .free_bits (~st_q.used[QUARTER-1:0]),
        .count     (free_cnt_lo)
    );

    pool_free_count #(.N(UPPER), .CW(CW)) u_cnt_hi (
        .free_bits (~st_q.used[NUM_SLOTS-1:QUARTER]),
        .count     (free_cnt_hi)
    );

    assign req_ready   = 1'b1;
    assign grant_valid = st_q.gvalid;
    assign grant_fail  = st_q.gfail;
    assign grant_idx   = st_q.gidx;

endmodule

// File: rtl/slot_pool_alloc_chk.sv
module slot_pool_alloc_chk #(
    parameter int NUM_SLOTS = 32,
    parameter int IW        = $clog2(NUM_SLOTS),
    parameter int CW        = $clog2(NUM_SLOTS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_outbound,
    input logic          free_valid,
    input logic          grant_valid,
    input logic          grant_fail,
    input logic [IW-1:0] grant_idx,
    input logic [CW-1:0] free_cnt_lo,
    input logic [CW-1:0] free_cnt_hi
);
    localparam int QUARTER = NUM_SLOTS / 4;

    logic [CW:0] total_free;
    assign total_free = {1'b0, free_cnt_lo} + {1'b0, free_cnt_hi};

    // R9: a request yields a result in the following cycle
    a_r9_grant_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> grant_valid);

    // R9: no result without a request
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !grant_valid);

    // R4: a failed request reports index zero
    a_r4_fail_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_fail) |-> (grant_idx == '0));

    // R3: outbound grants stay out of the reserved quarter
    a_r3_out_upper: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid && req_outbound) && grant_valid && !grant_fail)
        |-> (int'(grant_idx) >= QUARTER));

    // R5: a successful grant removes exactly one free slot
    a_r5_one_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !grant_fail && !$past(free_valid))
        |-> (total_free == $past(total_free) - 1'b1));

    // R10: partition counts never exceed partition sizes
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(free_cnt_lo) <= QUARTER) && (int'(free_cnt_hi) <= NUM_SLOTS - QUARTER));

endmodule

bind slot_pool_alloc slot_pool_alloc_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_outbound (req_outbound),
    .free_valid   (free_valid),
    .grant_valid  (grant_valid),
    .grant_fail   (grant_fail),
    .grant_idx    (grant_idx),
    .free_cnt_lo  (free_cnt_lo),
    .free_cnt_hi  (free_cnt_hi)
);

// File: tb/sim_slot_pool_alloc.sv
`timescale 1ns/1ps
module sim_slot_pool_alloc;
    localparam int N  = 32;
    localparam int IW = 5;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_outbound = 1'b0;
    logic          free_valid = 1'b0;
    logic [IW-1:0] free_idx = '0;
    logic          grant_valid;
    logic          grant_fail;
    logic [IW-1:0] grant_idx;
    logic [CW-1:0] free_cnt_lo;
    logic [CW-1:0] free_cnt_hi;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    slot_pool_alloc #(.NUM_SLOTS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_outbound(req_outbound), .free_valid(free_valid), .free_idx(free_idx),
        .grant_valid(grant_valid), .grant_fail(grant_fail), .grant_idx(grant_idx),
        .free_cnt_lo(free_cnt_lo), .free_cnt_hi(free_cnt_hi)
    );

    typedef struct packed {
        logic          req;
        logic          outb;
        logic          fv;
        logic [IW-1:0] fidx;
        logic          gv;
        logic          fail;
        logic [IW-1:0] idx;
        logic [CW-1:0] lo;
        logic [CW-1:0] hi;
    } vec_t;

    // Stimulus from reset; each row is one cycle
    localparam vec_t TAB [7] = '{
        '{1'b1, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 5'd0, 6'd7, 6'd24}, // R2 in -> 0
        '{1'b1, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 5'd8, 6'd7, 6'd23}, // R3 out -> 8
        '{1'b1, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 5'd1, 6'd6, 6'd23}, // R5 in -> 1
        '{1'b1, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 5'd9, 6'd7, 6'd22}, // R7 free 0 + out
        '{1'b1, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 5'd0, 6'd6, 6'd22}, // R6 reuse 0
        '{1'b0, 1'b0, 1'b1, 5'd1, 1'b0, 1'b0, 5'd0, 6'd7, 6'd22}, // R9 free only
        '{1'b1, 1'b1, 1'b1, 5'd8, 1'b1, 1'b0, 5'd8, 6'd7, 6'd22}  // R8 free 8 + out
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, sample at the following falling edge
    task automatic step(input logic rq, input logic ob, input logic fv, input int fi);
        req_valid    = rq;
        req_outbound = ob;
        free_valid   = fv;
        free_idx     = IW'(fi);
        @(posedge clk);
        @(negedge clk);
        req_valid  = 1'b0;
        free_valid = 1'b0;
    endtask

    task automatic chk_grant(input string req, input int gv, input int fl, input int ix);
        chk(req, "grant_valid", int'(grant_valid), gv);
        chk(req, "grant_fail", int'(grant_fail), fl);
        chk(req, "grant_idx", int'(grant_idx), ix);
    endtask

    task automatic chk_cnt(input string req, input int lo, input int hi);
        chk(req, "free_cnt_lo", int'(free_cnt_lo), lo);
        chk(req, "free_cnt_hi", int'(free_cnt_hi), hi);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_cnt("R1", 8, 24);
        chk("R1", "grant_valid", int'(grant_valid), 0);
        chk("R9", "req_ready", int'(req_ready), 1);

        foreach (TAB[i]) begin
            step(TAB[i].req, TAB[i].outb, TAB[i].fv, int'(TAB[i].fidx));
            chk_grant($sformatf("R2/R3/R6/R7/R8 row%0d", i),
                      int'(TAB[i].gv), int'(TAB[i].fail), int'(TAB[i].idx));
            chk_cnt($sformatf("R10 row%0d", i), int'(TAB[i].lo), int'(TAB[i].hi));
        end

        // R2: fill the reserved quarter in ascending order
        for (int k = 1; k < 8; k++) begin
            step(1'b1, 1'b0, 1'b0, 0);
            chk_grant("R2", 1, 0, k);
        end
        chk_cnt("R10", 0, 22);

        // R11: inbound spills to the lowest free upper slot
        step(1'b1, 1'b0, 1'b0, 0);
        chk_grant("R11", 1, 0, 10);

        // R3: outbound fills the remaining upper slots in order
        for (int k = 11; k < 32; k++) begin
            step(1'b1, 1'b1, 1'b0, 0);
            chk_grant("R3", 1, 0, k);
        end
        chk_cnt("R10", 0, 0);

        // R4: exhaustion for both classes
        step(1'b1, 1'b1, 1'b0, 0);
        chk_grant("R4", 1, 1, 0);
        step(1'b1, 1'b0, 1'b0, 0);
        chk_grant("R4", 1, 1, 0);
        chk_cnt("R4", 0, 0);

        // R3: a freed reserved slot is invisible to outbound
        step(1'b1, 1'b1, 1'b1, 3);
        chk_grant("R3", 1, 1, 0);
        chk_cnt("R3", 1, 0);

        // R6: freed slot granted on the next cycle
        step(1'b1, 1'b0, 1'b0, 0);
        chk_grant("R6", 1, 0, 3);

        // R8: free and request together on a full pool
        step(1'b1, 1'b0, 1'b1, 3);
        chk_grant("R8", 1, 0, 3);
        chk_cnt("R8", 0, 0);

        // R1: reset again clears every used bit
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_cnt("R1", 8, 24);
        chk("R1", "grant_valid", int'(grant_valid), 0);

        finish_run();
    end
endmodule